// File: doc/BRIEF.md
# Way-Group Cache Partition Controller

This block decides how much of an on-chip SRAM works as the data store of a set-associative cache and how much remains plain addressable memory. The cache has 32 ways per set, arranged as 8 groups of 4 ways. Way number w belongs to group w/4, so group g holds ways 4g through 4g+3. Software writes a 4-bit size field that gives the number of groups handed to the cache. The block turns that number into a way-enable mask for the cache lookup logic and into an address limit for the memory-mapped window.

The memory-mapped window always starts at offset 0 and stays contiguous. Every group given to the cache removes one region of `GROUP_BYTES` from the top of the window, so the cache appears to grow downward. A memory access that lands in a removed region gets an addressing error instead of data.

A change of size is not instant. When the cache grows, each new group's region is fenced first, and only then are that group's ways enabled. When the cache shrinks, each departing group must finish a flush/invalidate handshake before its ways are dropped, and only then is its region returned to memory. A busy bit stays set for the whole sequence. The size read back stays at the old value until the busy bit clears.

Top module: `wgcache_part_ctrl`

## Requirements
- R1: While reset is held and right after it, the readback is 0 (size 0, busy 0), the way mask is all zero, `flush_req` is low and no access raises `mem_err`.
- R2: `cfg_rdata[3:0]` holds the committed group count and `cfg_rdata[4]` is the busy bit, which is 1 exactly while a resize is in progress.
- R3: When idle with a committed count N, `way_en` has bits 0 to 4N-1 set and all others clear (group g drives bits 4g..4g+3).
- R4: A written value above 8 is treated as 8.
- R5: Writing the committed value sets busy for exactly one cycle and changes neither the mask nor the window.
- R6: Growing from A to B groups keeps busy for 2(B-A)+1 cycles. Groups are taken in ascending order, and each group's region errors for one cycle before its four ways appear in the mask. `flush_req` stays low.
- R7: Shrinking from A to B groups issues one `flush_req` for each departing group, from highest to lowest, with `flush_grp` naming the group. `flush_req` is held until `flush_ack`. The group's ways leave the mask in the cycle after the acknowledge, and its region is returned to memory one cycle after that.
- R8: Writes made while busy are ignored. The readback shows the old count until busy drops, and in that same cycle it shows the new count.
- R9: `mem_err` is 1 exactly when `mem_req` is 1 and `mem_offset` is at or above `SRAM_BYTES - F*GROUP_BYTES`, where F is the number of fenced groups (equal to the committed count when idle).
- R10: An access to the region of any group whose ways are enabled always raises `mem_err`.
- R11: `flush_ack` has no effect unless `flush_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the size field |
| cfg_wdata | input | 4 | Requested group count |
| cfg_rdata | output | 5 | {busy, committed group count} |
| way_en | output | 32 | Active-way enable mask |
| flush_req | output | 1 | Flush/invalidate request for a departing group |
| flush_grp | output | 3 | Group index of the current flush request |
| flush_ack | input | 1 | Flush/invalidate done |
| mem_req | input | 1 | Memory-mapped access valid |
| mem_offset | input | OFS_W (10) | Access offset from the SRAM base |
| mem_err | output | 1 | Addressing error for the access |

## Verification
A fence counter that lags the enable counter would let an enabled group's ways be read as memory. That shows up at once as a missing `mem_err` on the boundary probe made in the same cycle the mask bits appear. A wrong step order or a skipped state changes the busy length and the per-cycle pairing of mask width and error boundary, and the bench compares both on every cycle of a resize. A group index or count that is off by one shows up on `flush_grp` at the first request, or in the final readback the cycle busy drops.

// File: rtl/wgp_pkg.sv
`timescale 1ns/1ps
package wgp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_G_FENCE   = 3'd1,
    ST_G_ENABLE  = 3'd2,
    ST_S_REQ     = 3'd3,
    ST_S_UNFENCE = 3'd4,
    ST_FINISH    = 3'd5
  } wgp_state_e;

endpackage

// File: rtl/wgp_seq.sv
`timescale 1ns/1ps
module wgp_seq
  import wgp_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int SZ_W       = 4,
  localparam int CNT_W     = $clog2(NUM_GROUPS + 1),
  localparam int GRP_W     = $clog2(NUM_GROUPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SZ_W-1:0]  wr_size,
  input  logic             flush_ack,
  output logic             busy,
  output logic [CNT_W-1:0] commit_n,
  output logic [CNT_W-1:0] en_n,
  output logic [CNT_W-1:0] fence_n,
  output logic             flush_req,
  output logic [GRP_W-1:0] flush_grp
);

  localparam logic [CNT_W-1:0] MAX_N = CNT_W'(NUM_GROUPS);

  wgp_state_e       st_q, st_d;
  logic [CNT_W-1:0] tgt_q, tgt_d;
  logic [CNT_W-1:0] en_q, en_d;
  logic [CNT_W-1:0] fen_q, fen_d;
  logic [CNT_W-1:0] com_q, com_d;
  logic [CNT_W-1:0] wr_val;
  logic             upd;

  // requested count, limited to the number of groups
  always_comb begin
    if (wr_size > SZ_W'(NUM_GROUPS)) wr_val = MAX_N;
    else                             wr_val = CNT_W'(wr_size);
  end

  always_comb begin
    st_d  = st_q;
    tgt_d = tgt_q;
    en_d  = en_q;
    fen_d = fen_q;
    com_d = com_q;
    unique case (st_q)
      ST_IDLE: begin
        if (wr_en) begin
          tgt_d = wr_val;
          if (wr_val > com_q)      st_d = ST_G_FENCE;
          else if (wr_val < com_q) st_d = ST_S_REQ;
          else                     st_d = ST_FINISH;
        end
      end
      ST_G_FENCE: begin
        fen_d = fen_q + 1'b1;
        st_d  = ST_G_ENABLE;
      end
      ST_G_ENABLE: begin
        en_d = en_q + 1'b1;
        st_d = ((en_q + 1'b1) == tgt_q) ? ST_FINISH : ST_G_FENCE;
      end
      ST_S_REQ: begin
        if (flush_ack) begin
          en_d = en_q - 1'b1;
          st_d = ST_S_UNFENCE;
        end
      end
      ST_S_UNFENCE: begin
        fen_d = fen_q - 1'b1;
        st_d  = ((fen_q - 1'b1) == tgt_q) ? ST_FINISH : ST_S_REQ;
      end
      ST_FINISH: begin
        com_d = tgt_q;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign upd = (st_q != ST_IDLE) || wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tgt_q <= '0;
      en_q  <= '0;
      fen_q <= '0;
      com_q <= '0;
    end else if (upd) begin
      st_q  <= st_d;
      tgt_q <= tgt_d;
      en_q  <= en_d;
      fen_q <= fen_d;
      com_q <= com_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign commit_n  = com_q;
  assign en_n      = en_q;
  assign fence_n   = fen_q;
  assign flush_req = (st_q == ST_S_REQ);
  assign flush_grp = GRP_W'(en_q - 1'b1);

  // enabled groups are always a subset of fenced groups, at most one apart
  p_fence_covers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fen_q >= en_q) && ((fen_q - en_q) <= CNT_W'(1)));

  p_flush_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && !flush_ack) |=> (flush_req && $stable(flush_grp)));

  p_busy_ignores_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st_q != ST_FINISH) |=> ($stable(com_q) && $stable(tgt_q)));

  p_idle_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (en_q == com_q && fen_q == com_q));

  p_clamped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (com_q <= MAX_N) && (tgt_q <= MAX_N));

  p_stray_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_ack && !flush_req) |=> $stable(en_q));

endmodule

// File: rtl/wgp_mask.sv
`timescale 1ns/1ps
module wgp_mask #(
  parameter int NUM_GROUPS     = 8,
  parameter int WAYS_PER_GROUP = 4,
  localparam int CNT_W         = $clog2(NUM_GROUPS + 1),
  localparam int WAYS          = NUM_GROUPS * WAYS_PER_GROUP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] en_n,
  output logic [WAYS-1:0]  way_en
);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign way_en[g*WAYS_PER_GROUP +: WAYS_PER_GROUP] =
      {WAYS_PER_GROUP{en_n > CNT_W'(g)}};
  end

  // mask is a run of ones starting at way 0
  p_mask_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((way_en + WAYS'(1)) & way_en) == '0);

  p_mask_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(way_en ^ $past(way_en)) == 0) ||
    ($countones(way_en ^ $past(way_en)) == WAYS_PER_GROUP));

endmodule

// File: rtl/wgp_window.sv
`timescale 1ns/1ps
module wgp_window #(
  parameter int NUM_GROUPS  = 8,
  parameter int SRAM_BYTES  = 1024,
  parameter int GROUP_BYTES = 64,
  localparam int CNT_W      = $clog2(NUM_GROUPS + 1),
  localparam int OFS_W      = $clog2(SRAM_BYTES),
  localparam int LIM_W      = OFS_W + 1
) (
  input  logic             mem_req,
  input  logic [OFS_W-1:0] mem_offset,
  input  logic [CNT_W-1:0] fence_n,
  output logic             mem_err
);

  logic [LIM_W-1:0] limit;

  always_comb begin
    limit   = LIM_W'(SRAM_BYTES) - (LIM_W'(fence_n) * LIM_W'(GROUP_BYTES));
    mem_err = mem_req && ({1'b0, mem_offset} >= limit);
  end

endmodule

// File: rtl/wgcache_part_ctrl.sv
`timescale 1ns/1ps
module wgcache_part_ctrl #(
  parameter int NUM_GROUPS     = 8,
  parameter int WAYS_PER_GROUP = 4,
  parameter int SRAM_BYTES     = 1024,
  parameter int GROUP_BYTES    = 64,
  localparam int SZ_W          = 4,
  localparam int CNT_W         = $clog2(NUM_GROUPS + 1),
  localparam int GRP_W         = $clog2(NUM_GROUPS),
  localparam int WAYS          = NUM_GROUPS * WAYS_PER_GROUP,
  localparam int OFS_W         = $clog2(SRAM_BYTES),
  localparam int LIM_W         = OFS_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [SZ_W-1:0]  cfg_wdata,
  output logic [SZ_W:0]    cfg_rdata,
  output logic [WAYS-1:0]  way_en,
  output logic             flush_req,
  output logic [GRP_W-1:0] flush_grp,
  input  logic             flush_ack,
  input  logic             mem_req,
  input  logic [OFS_W-1:0] mem_offset,
  output logic             mem_err
);

  logic             busy;
  logic [CNT_W-1:0] commit_n;
  logic [CNT_W-1:0] en_n;
  logic [CNT_W-1:0] fence_n;

  wgp_seq #(.NUM_GROUPS(NUM_GROUPS), .SZ_W(SZ_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wr_size   (cfg_wdata),
    .flush_ack (flush_ack),
    .busy      (busy),
    .commit_n  (commit_n),
    .en_n      (en_n),
    .fence_n   (fence_n),
    .flush_req (flush_req),
    .flush_grp (flush_grp)
  );

  wgp_mask #(.NUM_GROUPS(NUM_GROUPS), .WAYS_PER_GROUP(WAYS_PER_GROUP)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_n   (en_n),
    .way_en (way_en)
  );

  wgp_window #(.NUM_GROUPS(NUM_GROUPS), .SRAM_BYTES(SRAM_BYTES),
               .GROUP_BYTES(GROUP_BYTES)) u_win (
    .mem_req    (mem_req),
    .mem_offset (mem_offset),
    .fence_n    (fence_n),
    .mem_err    (mem_err)
  );

  assign cfg_rdata = {busy, SZ_W'(commit_n)};

  // lowest offset owned by an enabled group
  logic [LIM_W-1:0] en_floor;
  assign en_floor = LIM_W'(SRAM_BYTES) - (LIM_W'(en_n) * LIM_W'(GROUP_BYTES));

  p_enabled_fenced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ({1'b0, mem_offset} >= en_floor)) |-> mem_err);

  p_no_req_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !mem_err);

endmodule

// File: tb/sim_wgcache_part_ctrl.sv
`timescale 1ns/1ps
module sim_wgcache_part_ctrl;

  localparam int NG   = 8;
  localparam int SRAM = 1024;
  localparam int GB   = 64;
  localparam int OFSW = 10;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_wr;
  logic [3:0]      cfg_wdata;
  logic [4:0]      cfg_rdata;
  logic [31:0]     way_en;
  logic            flush_req;
  logic [2:0]      flush_grp;
  logic            flush_ack;
  logic            mem_req;
  logic [OFSW-1:0] mem_offset;
  logic            mem_err;

  int n_chk = 0;
  int n_err = 0;
  int cur_m = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  wgcache_part_ctrl #(.NUM_GROUPS(NG), .WAYS_PER_GROUP(4),
                      .SRAM_BYTES(SRAM), .GROUP_BYTES(GB)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .way_en(way_en), .flush_req(flush_req),
    .flush_grp(flush_grp), .flush_ack(flush_ack), .mem_req(mem_req),
    .mem_offset(mem_offset), .mem_err(mem_err)
  );

  function automatic logic [31:0] f_mask(int n);
    logic [63:0] m;
    m = (64'd1 << (4 * n)) - 64'd1;
    return m[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // boundary probe of the window for f fenced groups (R9)
  task automatic probe(input int f, input string req);
    mem_req = 1'b1;
    if (f > 0) begin
      mem_offset = OFSW'(SRAM - f * GB);
      #0.2;
      chk(mem_err === 1'b1, req, {31'd0, mem_err}, 32'd1);
    end
    if (f < NG) begin
      mem_offset = OFSW'(SRAM - f * GB - 1);
      #0.2;
      chk(mem_err === 1'b0, req, {31'd0, mem_err}, 32'd0);
    end
    mem_req = 1'b0;
    #0.2;
    chk(mem_err === 1'b0, "R9", {31'd0, mem_err}, 32'd0);
  endtask

  task automatic cyc(input bit b, input int sz, input int en, input int fen,
                     input bit freq, input string req);
    #0.2;
    chk(cfg_rdata === {b, 4'(sz)}, req, {27'd0, cfg_rdata}, {27'd0, b, 4'(sz)});
    chk(way_en === f_mask(en), req, way_en, f_mask(en));
    chk(flush_req === freq, req, {31'd0, flush_req}, {31'd0, freq});
    probe(fen, req);
  endtask

  task automatic resize(input int v, input bit poke);
    int a, b;
    a = cur_m;
    b = (v > NG) ? NG : v;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 4'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
    if (b >= a) begin
      for (int i = 0; i <= 2 * (b - a); i++) begin
        cyc(1'b1, a, a + i / 2, a + (i + 1) / 2, 1'b0, (b == a) ? "R5" : "R6");
        if (poke && i == 0) begin
          cfg_wr = 1'b1; cfg_wdata = 4'(NG - b);
          flush_ack = 1'b1;
        end
        @(negedge clk);
        cfg_wr = 1'b0; flush_ack = 1'b0;
      end
    end else begin
      for (int g = a - 1; g >= b; g--) begin
        int d;
        d = int'($urandom % 4);
        for (int k = 0; k <= d; k++) begin
          cyc(1'b1, a, g + 1, g + 1, 1'b1, "R7");
          chk(flush_grp === 3'(g), "R7", {29'd0, flush_grp}, g);
          if (poke && k == 0) begin cfg_wr = 1'b1; cfg_wdata = 4'(a); end
          if (k == d) flush_ack = 1'b1;
          @(negedge clk);
          cfg_wr = 1'b0; flush_ack = 1'b0;
        end
        cyc(1'b1, a, g, g + 1, 1'b0, "R7");
        @(negedge clk);
      end
      cyc(1'b1, a, b, b, 1'b0, "R8");
      @(negedge clk);
    end
    cyc(1'b0, b, b, b, 1'b0, (v > NG) ? "R4" : "R8");
    cur_m = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_wdata = '0; flush_ack = 1'b0;
    mem_req = 1'b0; mem_offset = '0;
    repeat (3) @(negedge clk);
    cyc(1'b0, 0, 0, 0, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b0, 0, 0, 0, 1'b0, "R1");
    chk(cfg_rdata[4] === 1'b0, "R2", {31'd0, cfg_rdata[4]}, 0);

    // stray acknowledge while idle (R11)
    flush_ack = 1'b1;
    @(negedge clk);
    flush_ack = 1'b0;
    @(negedge clk);
    cyc(1'b0, 0, 0, 0, 1'b0, "R11");

    resize(3, 1'b0);           // grow R6
    resize(3, 1'b1);           // same value R5, write during busy ignored
    resize(15, 1'b1);          // clamp R4, grow with poke R8/R11
    chk(way_en === 32'hFFFF_FFFF, "R3", way_en, 32'hFFFF_FFFF);
    resize(5, 1'b1);           // shrink R7 with poke R8
    resize(0, 1'b0);           // shrink to empty
    chk(way_en === 32'd0, "R3", way_en, 32'd0);
    resize(8, 1'b0);
    resize(9, 1'b0);           // clamp to current value R4/R5

    for (int r = 0; r < 30; r++) begin
      resize(int'($urandom % 16), bit'($urandom % 2));
      for (int m = 0; m < 4; m++) begin
        int off;
        bit e;
        off = int'($urandom % SRAM);
        e = (off >= SRAM - cur_m * GB);
        mem_req = 1'b1; mem_offset = OFSW'(off);
        #0.2;
        chk(mem_err === e, "R9", {31'd0, mem_err}, {31'd0, e});
        if (off >= SRAM - cur_m * GB)
          chk(mem_err === 1'b1, "R10", {31'd0, mem_err}, 1);
        mem_req = 1'b0;
        @(negedge clk);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule